// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers single-cycle event pulses from several sources (cadence timers, per-transistor power alarms, line detectors and an indirect register access engine) into three banks of eight pending bits. Each bank has a matching enable bank. An event is latched only when its enable bit is already set, so the enable gates the capture itself and not only the output. Software clears pending bits by writing ones to them.

The block drives one active-low interrupt line that is low while any pending bit is set. Registers are reached through a byte-wide port with a combinational read. The serial bus that carries the accesses and the logic that produces the events lie outside the block.

Top module: `irq_aggr`

## Requirements
- R1: After reset every pending and enable bit is zero and `irq_no` is high.
- R2: An event bit is latched at a clock edge only if its enable bit held 1 before that edge. An enable written at the same edge as the event does not capture it.
- R3: Writing a data byte to a pending bank clears each bit where the byte holds 1. Bits where the byte holds 0 keep their value, and a 1 written to a bit that is not pending leaves it at 0.
- R4: If an enabled event and a clearing write hit the same bit at the same edge, the bit ends up set.
- R5: A single-cycle event pulse is enough. The bit stays pending through idle cycles until it is cleared.
- R6: Clearing an enable bit leaves an already pending bit set.
- R7: `irq_no` is low exactly while at least one pending bit is set.
- R8: Only the implemented bits exist: bank 0 bits 5:0, bank 1 bits 7:0 and bank 2 bit 1. All other positions read 0, cannot be enabled and never latch an event.
- R9: Pending bank k is at address k and enable bank k is at address 3+k. Event input bit 8k+j feeds bit j of bank k. Addresses 6 and 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 24 | Event pulses, bit 8k+j goes to bank k bit j |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_no | output | 1 | Interrupt line, active low |

## Verification
The bench fires an event in the same cycle as the write that sets its enable. A design that used the new enable would latch the event. It also fires an event in the same cycle as a clearing write to that bit, and a design that let the clear win would drop the event. It clears an enable while its bit is pending, which exposes a design that masks the stored bits, and it sends events and enable writes on reserved positions, which exposes an implementation with a full 8-bit mask. Writes of zeros, writes to unused addresses and writes of ones to idle bits show whether any of them can set or disturb state.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 8;
  localparam int ADDR_W    = 3;
  // implemented bits, bank 2 in the top byte
  localparam logic [NUM_BANKS*BANK_W-1:0] IMPL_MASK = 24'h02_FF_3F;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int               BW   = 8,
  parameter logic [BW-1:0]    MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] evt_i,
  input  logic          sts_wr_i,
  input  logic          en_wr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] sts_o,
  output logic [BW-1:0] en_o
);
  logic [BW-1:0] sts_q, en_q, hit, clr;

  assign hit = evt_i & en_q & MASK;
  assign clr = sts_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr) | hit) & MASK; // set dominates clear
      if (en_wr_i) en_q <= wdata_i & MASK;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;

  for (genvar b = 0; b < BW; b++) begin : g_bit_chk
    AST_SET_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(sts_q[b]) && sts_q[b]) |-> $past(en_q[b] && evt_i[b])); // R2
    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_wr_i && wdata_i[b] && !(evt_i[b] && en_q[b])) |=> !sts_q[b]); // R3
    AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[b] && en_q[b] && MASK[b]) |=> sts_q[b]); // R4
    AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_q[b] && !(sts_wr_i && wdata_i[b])) |=> sts_q[b]); // R6
  end
endmodule

// File: rtl/irq_regif.sv
module irq_regif #(
  parameter int NB = 3,
  parameter int BW = 8,
  parameter int AW = 3
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [NB*BW-1:0] sts_i,
  input  logic [NB*BW-1:0] en_i,
  output logic [NB-1:0]    sts_wr_o,
  output logic [NB-1:0]    en_wr_o,
  output logic [BW-1:0]    rdata_o
);
  for (genvar k = 0; k < NB; k++) begin : g_dec
    assign sts_wr_o[k] = wr_en_i && (addr_i == AW'(k));
    assign en_wr_o[k]  = wr_en_i && (addr_i == AW'(NB + k));
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (addr_i == AW'(k))      rdata_o = sts_i[k*BW +: BW];
      if (addr_i == AW'(NB + k)) rdata_o = en_i[k*BW +: BW];
    end
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N = 24
) (
  input  logic [N-1:0] pend_i,
  output logic         irq_no
);
  assign irq_no = ~|pend_i;
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int                   NB   = NUM_BANKS,
  parameter int                   BW   = BANK_W,
  parameter int                   AW   = ADDR_W,
  parameter logic [NB*BW-1:0]     MASK = IMPL_MASK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NB*BW-1:0] evt_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [BW-1:0]    wdata_i,
  output logic [BW-1:0]    rdata_o,
  output logic             irq_no
);
  localparam int TOTAL = NB * BW;

  logic [TOTAL-1:0] sts_all, en_all;
  logic [NB-1:0]    sts_wr, en_wr;

  irq_regif #(.NB(NB), .BW(BW), .AW(AW)) i_regif (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .sts_i    (sts_all),
    .en_i     (en_all),
    .sts_wr_o (sts_wr),
    .en_wr_o  (en_wr),
    .rdata_o  (rdata_o)
  );

  for (genvar k = 0; k < NB; k++) begin : g_bank
    irq_bank #(.BW(BW), .MASK(MASK[k*BW +: BW])) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[k*BW +: BW]),
      .sts_wr_i (sts_wr[k]),
      .en_wr_i  (en_wr[k]),
      .wdata_i  (wdata_i),
      .sts_o    (sts_all[k*BW +: BW]),
      .en_o     (en_all[k*BW +: BW])
    );
  end

  irq_combine #(.N(TOTAL)) i_combine (
    .pend_i (sts_all),
    .irq_no (irq_no)
  );

  AST_IRQ_LOW_WHEN_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_all != '0) |-> !irq_no); // R7
  AST_IRQ_HIGH_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_all == '0) |-> irq_no); // R7
  AST_RSVD_NEVER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & ~MASK) != '0) |=> ((sts_all & ~MASK) == '0)); // R8
endmodule

// File: tb/test_irq_aggr.sv
module test_irq_aggr;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int BW = 8;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic [23:0]   evt_i = '0;
  logic [2:0]    addr_i = '0;
  logic          wr_en_i = 0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic          irq_no;

  int n_vec = 0;
  int n_err = 0;
  bit done = 0;

  logic [7:0] sts_m [NB];
  logic [7:0] en_m  [NB];

  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_aggr i_irq_aggr (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  function automatic logic [7:0] msk(int k);
    case (k)
      0: return 8'h3F;
      1: return 8'hFF;
      2: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  // one cycle of stimulus; model advances to the state after the next edge
  task automatic cyc(input logic [23:0] evt, input bit we, input logic [2:0] a,
                     input logic [7:0] d);
    logic [7:0] en_old [NB];
    @(posedge clk_i); #1;
    evt_i = evt; wr_en_i = we; addr_i = a; wdata_i = d;
    for (int k = 0; k < NB; k++) en_old[k] = en_m[k];
    for (int k = 0; k < NB; k++) begin
      logic [7:0] c;
      c = (we && a == 3'(k)) ? d : 8'h00;
      sts_m[k] = ((sts_m[k] & ~c) | (evt[k*8 +: 8] & en_old[k])) & msk(k);
      if (we && a == 3'(3 + k)) en_m[k] = d & msk(k);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    logic [7:0] ed;
    bit any;
    @(posedge clk_i); #1;
    evt_i = '0; wr_en_i = 0; wdata_i = '0; addr_i = a;
    ed = 8'h00;
    any = 0;
    for (int k = 0; k < NB; k++) begin
      if (a == 3'(k))     ed = sts_m[k];
      if (a == 3'(3 + k)) ed = en_m[k];
      if (sts_m[k] != 0)  any = 1;
    end
    exp_q.push_back({!any, ed});
    tag_q.push_back(tag);
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 8; a++) rd(3'(a), tag);
  endtask

  // monitor: compare one expected item per cycle
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if ({irq_no, rdata_o} !== e) begin
        n_err++;
        $display("FAIL %s addr=%0d actual irq_n=%b data=%h expected irq_n=%b data=%h",
                 t, addr_i, irq_no, rdata_o, e[8], e[7:0]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    logic [23:0] lfsr;
    for (int k = 0; k < NB; k++) begin sts_m[k] = 0; en_m[k] = 0; end
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    rd_all("R1 reset state");

    // R8 R9: enable all, reserved bits stay zero; unused address write ignored
    for (int k = 0; k < NB; k++) cyc('0, 1, 3'(3 + k), 8'hFF);
    cyc('0, 1, 3'd6, 8'hFF);
    cyc('0, 1, 3'd7, 8'hFF);
    rd_all("R8_R9 enable readback");

    // R5 R7: single pulse on bank1 bit3 held through idle cycles
    cyc(24'h00_08_00, 0, 3'd0, 8'h00);
    rd(3'd1, "R5 pulse latched");
    repeat (5) cyc('0, 0, 3'd0, 8'h00);
    rd(3'd1, "R5_R7 held and irq low");

    // R3: zero write keeps, one on idle bit stays zero, one clears
    cyc('0, 1, 3'd1, 8'h00);
    rd(3'd1, "R3 zero write no effect");
    cyc('0, 1, 3'd1, 8'hF7);
    rd(3'd1, "R3 ones on idle bits");
    cyc('0, 1, 3'd1, 8'h08);
    rd(3'd1, "R3_R7 cleared irq high");

    // R2: masked event dropped
    cyc('0, 1, 3'd3, 8'h3B);
    cyc(24'h00_00_04, 0, 3'd0, 8'h00);
    rd(3'd0, "R2 masked event dropped");
    // R2: enable written in same cycle as event does not capture
    cyc('0, 1, 3'd5, 8'h00);
    cyc(24'h02_00_00, 1, 3'd5, 8'h02);
    rd(3'd2, "R2 same-cycle enable");
    cyc(24'h02_00_00, 0, 3'd0, 8'h00);
    rd(3'd2, "R2 enabled event latched");

    // R4: event and clear same bit same cycle
    cyc(24'h02_00_00, 1, 3'd2, 8'h02);
    rd(3'd2, "R4 event wins over clear");

    // R6: dropping the enable keeps pending
    cyc('0, 1, 3'd5, 8'h00);
    rd(3'd2, "R6 pending kept");
    rd(3'd5, "R6 enable off");

    // R8: reserved events in banks 0 and 2 ignored
    cyc(24'hFD_00_C0, 0, 3'd0, 8'h00);
    rd(3'd0, "R8 reserved bank0");
    rd(3'd2, "R8 reserved bank2");
    cyc('0, 1, 3'd2, 8'hFF);
    rd_all("R7_R9 all clear");

    // pattern sweep
    lfsr = 24'hACE1F3;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
      cyc(lfsr, lfsr[3], 3'(lfsr[10:8]), lfsr[19:12]);
      rd(3'(lfsr[6:4]), "R2_R3_R4 sweep");
    end
    rd_all("R9 sweep final");

    repeat (3) @(posedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule